// File: doc/BRIEF.md
# PLL Configuration Register with Write Lockout

This block holds the three settings of a clock synthesizer in one 32-bit register that sits on a simple bus write port with byte strobes. The settings are an input pre-divider ahead of the VCO, a 9-bit VCO multiplier and a 2-bit output post-divider code. The block always returns the stored settings on its read data port. It also presents the post-divider as a plain divide ratio and shows whether the stored settings are all legal.

The block drops a field update when the PLL that field affects is running. It also drops a multiplier update when the write is narrower than a half-word. Two live status lines drive these rules, one for the main PLL and one for the audio PLL. A dropped update sets a sticky flag, which software clears through a dedicated input. The block checks the legal ranges of the stored values but does not enforce them. An out-of-range value is stored as written and only lowers the validity output.

Top module: `pll_cfg_reg`

## Requirements
- R1: After a synchronous active-low reset, the register reads 0x00003010: pre-divider 16, multiplier 192 and post-divider code 0. After reset, wr_blocked is 0.
- R2: The fields are packed as follows: the pre-divider in bits 5:0, the multiplier in bits 14:6 and the post-divider code in bits 17:16. Bit 15 and bits 31:18 read as zero and ignore written data.
- R3: post_div equals twice the post-divider code plus 2. Code 0 gives 2, 1 gives 4, 2 gives 6 and 3 gives 8.
- R4: While main_pll_on is high, writes to the multiplier and the post-divider are dropped.
- R5: While main_pll_on or audio_pll_on is high, writes to the pre-divider are dropped.
- R6: The multiplier is written only when wr_strb is 0011 (lower half-word) or 1111 (word). Any other strobe that has bit 0 or bit 1 set leaves the multiplier unchanged. The pre-divider follows strobe bit 0 and the post-divider follows strobe bit 2, so each of them accepts a single-byte write.
- R7: Nothing changes when wr_sel is low. Nothing changes when wr_sel is high with wr_strb equal to 0000.
- R8: cfg_valid is high exactly when the pre-divider is in 2..63 and the multiplier is in 64..432.
- R9: wr_blocked is set in the cycle after any write whose update of a strobed field is dropped. It then stays set until blk_clr is high. A new drop in the same cycle as blk_clr wins, and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| main_pll_on | input | 1 | Main PLL is running |
| audio_pll_on | input | 1 | Audio PLL is running |
| wr_sel | input | 1 | Address hit with write |
| wr_data | input | 32 | Write data |
| wr_strb | input | 4 | Byte strobes, bit n enables byte n |
| blk_clr | input | 1 | Clears wr_blocked |
| rd_data | output | 32 | Register readback |
| post_div | output | 4 | Decoded post-divide ratio |
| cfg_valid | output | 1 | All stored fields in range |
| wr_blocked | output | 1 | Sticky flag: a write update was dropped |

## Verification
The bench gates the pre-divider on the audio PLL alone. A design that gates it only on the main PLL would accept that write and show a changed low field. Single-byte writes to byte 0 and to byte 1 must drop the multiplier, and so must raise the sticky flag. The 1100 strobe must touch only the post-divider. A design that decodes access size loosely would corrupt bits 14:6 or miss the flag. Writes of 1, 433, 63 and 0 probe each edge of the legal ranges, and a design that clamps values or has off-by-one limits would show a wrong readback or a wrong cfg_valid. The bench also raises a drop and a clear in the same cycle, and writes with the strobe or the select inactive. A flag priority that is the wrong way round, or a write enable that is decoded loosely, is visible at the ports.

// File: rtl/pll_cfg_reg.sv
module pll_cfg_reg #(
  parameter int PRE_W   = 6,
  parameter int MUL_W   = 9,
  parameter int PST_W   = 2,
  parameter int PRE_MIN = 2,
  parameter int MUL_MIN = 64,
  parameter int MUL_MAX = 432,
  parameter int PRE_RST = 16,
  parameter int MUL_RST = 192,
  parameter int PST_RST = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        main_pll_on,
  input  logic        audio_pll_on,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  input  logic [3:0]  wr_strb,
  input  logic        blk_clr,
  output logic [31:0] rd_data,
  output logic [3:0]  post_div,
  output logic        cfg_valid,
  output logic        wr_blocked
);

  localparam int MUL_LSB = PRE_W;
  localparam int PST_LSB = 16;
  localparam logic [31:0] RW_MASK =
    (32'((1 << PRE_W) - 1)) | (32'((1 << MUL_W) - 1) << MUL_LSB) | (32'((1 << PST_W) - 1) << PST_LSB);

  logic [PRE_W-1:0] pre_q;
  logic [MUL_W-1:0] mul_q;
  logic [PST_W-1:0] pst_q;

  wire size_ok  = (wr_strb == 4'b0011) || (wr_strb == 4'b1111);
  wire pre_hit  = wr_sel & wr_strb[0];
  wire mul_hit  = wr_sel & (wr_strb[0] | wr_strb[1]);
  wire pst_hit  = wr_sel & wr_strb[2];
  wire pre_ok   = pre_hit & ~main_pll_on & ~audio_pll_on;
  wire mul_ok   = mul_hit & ~main_pll_on & size_ok;
  wire pst_ok   = pst_hit & ~main_pll_on;
  wire drop     = (pre_hit & ~pre_ok) | (mul_hit & ~mul_ok) | (pst_hit & ~pst_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= PRE_W'(PRE_RST);
      mul_q <= MUL_W'(MUL_RST);
      pst_q <= PST_W'(PST_RST);
    end else begin
      if (pre_ok) pre_q <= wr_data[PRE_W-1:0];
      if (mul_ok) mul_q <= wr_data[MUL_LSB +: MUL_W];
      if (pst_ok) pst_q <= wr_data[PST_LSB +: PST_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       wr_blocked <= 1'b0;
    else if (drop)    wr_blocked <= 1'b1;
    else if (blk_clr) wr_blocked <= 1'b0;
  end

  always_comb begin
    rd_data = '0;
    rd_data[PRE_W-1:0]        = pre_q;
    rd_data[MUL_LSB +: MUL_W] = mul_q;
    rd_data[PST_LSB +: PST_W] = pst_q;
  end

  assign post_div  = 4'({pst_q, 1'b0}) + 4'd2;
  assign cfg_valid = (32'(pre_q) >= PRE_MIN) && (32'(mul_q) >= MUL_MIN) && (32'(mul_q) <= MUL_MAX);

  AST_MUL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    main_pll_on |=> $stable(rd_data[MUL_LSB +: MUL_W])); // R4
  AST_PST_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    main_pll_on |=> $stable(post_div)); // R4
  AST_PRE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (main_pll_on || audio_pll_on) |=> $stable(rd_data[PRE_W-1:0])); // R5
  AST_MUL_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strb != 4'b0011 && wr_strb != 4'b1111) |=> $stable(rd_data[MUL_LSB +: MUL_W])); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_sel || wr_strb == 4'b0000) |=> $stable(rd_data)); // R7
  AST_WORD_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && wr_strb == 4'b1111 && !main_pll_on && !audio_pll_on)
      |=> rd_data == ($past(wr_data) & RW_MASK)); // R2
  AST_BLOCK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && wr_strb[2] && main_pll_on) |=> wr_blocked); // R9
  AST_BLOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_blocked && !blk_clr) |=> wr_blocked); // R9
  AST_DECODE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !post_div[0] && post_div >= 4'd2 && post_div <= 4'd8); // R3

endmodule

// File: tb/test_pll_cfg_reg.sv
module test_pll_cfg_reg;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic main_pll_on = 1'b0, audio_pll_on = 1'b0, wr_sel = 1'b0, blk_clr = 1'b0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_strb = '0;
  logic [31:0] rd_data;
  logic [3:0]  post_div;
  logic        cfg_valid, wr_blocked;
  int errors = 0, checks = 0;
  bit done = 0;

  pll_cfg_reg i_pll_cfg_reg (
    .clk(clk), .rst_n(rst_n), .main_pll_on(main_pll_on), .audio_pll_on(audio_pll_on),
    .wr_sel(wr_sel), .wr_data(wr_data), .wr_strb(wr_strb), .blk_clr(blk_clr),
    .rd_data(rd_data), .post_div(post_div), .cfg_valid(cfg_valid), .wr_blocked(wr_blocked)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {main, audio, strb, data, exp_rd, exp_blk, exp_valid, exp_post_div}
  localparam logic [75:0] VEC [0:NV-1] = '{
    {1'b0,1'b0,4'b1111,32'h00011904,32'h00011904,1'b0,1'b1,4'd4},
    {1'b1,1'b0,4'b1111,32'h00023208,32'h00011904,1'b1,1'b1,4'd4},
    {1'b0,1'b1,4'b1111,32'h00033208,32'h00033204,1'b1,1'b1,4'd8},
    {1'b0,1'b0,4'b0001,32'h00004B0A,32'h0003320A,1'b1,1'b1,4'd8},
    {1'b0,1'b0,4'b0011,32'h00006C02,32'h00036C02,1'b0,1'b1,4'd8},
    {1'b0,1'b0,4'b1100,32'hFFFC8000,32'h00006C02,1'b0,1'b1,4'd2},
    {1'b0,1'b0,4'b0100,32'h00010000,32'h00016C02,1'b0,1'b1,4'd4},
    {1'b1,1'b0,4'b0100,32'h00020000,32'h00016C02,1'b1,1'b1,4'd4},
    {1'b0,1'b0,4'b1111,32'h00006C41,32'h00006C41,1'b0,1'b0,4'd2},
    {1'b0,1'b0,4'b1111,32'h0003103F,32'h0003103F,1'b0,1'b1,4'd8},
    {1'b0,1'b0,4'b1111,32'h00000FC0,32'h00000FC0,1'b0,1'b0,4'd2},
    {1'b0,1'b0,4'b0010,32'h0000FF00,32'h00000FC0,1'b1,1'b0,4'd2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic m, input logic a, input logic [3:0] s, input logic [31:0] d);
    main_pll_on = m; audio_pll_on = a; wr_strb = s; wr_data = d; wr_sel = 1'b1;
    @(negedge clk);
    wr_sel = 1'b0; wr_strb = '0; main_pll_on = 1'b0; audio_pll_on = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset rd_data", rd_data, 32'h00003010);
    chk("R1 reset wr_blocked", {31'b0, wr_blocked}, 32'd0);
    chk("R3 reset post_div", {28'b0, post_div}, 32'd2);
    chk("R8 reset cfg_valid", {31'b0, cfg_valid}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][75], VEC[i][74], VEC[i][73:70], VEC[i][69:38]);
      chk($sformatf("R2 R4 R5 R6 vec%0d rd_data", i), rd_data, VEC[i][37:6]);
      chk($sformatf("R9 vec%0d wr_blocked", i), {31'b0, wr_blocked}, {31'b0, VEC[i][5]});
      chk($sformatf("R8 vec%0d cfg_valid", i), {31'b0, cfg_valid}, {31'b0, VEC[i][4]});
      chk($sformatf("R3 vec%0d post_div", i), {28'b0, post_div}, {28'b0, VEC[i][3:0]});
      blk_clr = 1'b1; @(negedge clk); blk_clr = 1'b0;
    end

    // R7: select low, then zero strobe
    wr_data = 32'h0003FFFF; wr_strb = 4'b1111; wr_sel = 1'b0;
    @(negedge clk);
    chk("R7 sel low ignored", rd_data, 32'h00000FC0);
    wr(1'b0, 1'b0, 4'b0000, 32'h0003FFFF);
    chk("R7 zero strobe ignored", rd_data, 32'h00000FC0);
    chk("R7 zero strobe no block", {31'b0, wr_blocked}, 32'd0);

    // R9: sticky hold, clear, and drop wins over clear
    wr(1'b1, 1'b0, 4'b0100, 32'h00030000);
    repeat (3) @(negedge clk);
    chk("R9 sticky holds", {31'b0, wr_blocked}, 32'd1);
    blk_clr = 1'b1; @(negedge clk); blk_clr = 1'b0;
    chk("R9 clear", {31'b0, wr_blocked}, 32'd0);
    blk_clr = 1'b1;
    wr(1'b0, 1'b1, 4'b0001, 32'h00000005);
    blk_clr = 1'b0;
    chk("R9 drop wins over clear", {31'b0, wr_blocked}, 32'd1);
    chk("R5 audio lock keeps pre", rd_data, 32'h00000FC0);

    // R1: reset mid-run
    wr(1'b0, 1'b0, 4'b1111, 32'h00025555);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    chk("R1 re-reset rd_data", rd_data, 32'h00003010);
    chk("R1 re-reset wr_blocked", {31'b0, wr_blocked}, 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule